// File: doc/BRIEF.md
# System Control Register Block

This block is the register file of a chip's system control unit, sitting on a simple 32-bit register bus that uses byte addresses with word-aligned accesses. It stores the clock configuration word, three banks of clock-gating words (run, sleep and deep-sleep), brown-out and LDO control, a reset-cause field, two general 32-bit control words, and two read-only words that present a factory MAC address. A seven-source interrupt controller offers three views: the raw status, the enable mask, and the pending (masked) status. It drives a single interrupt line.

The clock configuration word feeds two live decodes. The first is a clock scale value that is always five times one more than a 4-bit divider field. The second is a read-only PLL setting word, picked from one of two 16-entry tables by a crystal-select field and a chip-variant input. A write that clears the PLL power-down bit, when that bit was set, posts the PLL-lock interrupt source. Accesses that hit no register return zero, change nothing, and pulse an error flag.

Top module: `sysctl_regs`

Register map (byte offsets): 0x00 clock config, 0x04 PLL setting (read-only), 0x10 raw interrupt status (read-only), 0x14 interrupt enable, 0x18 pending interrupts (read; write-one-to-clear), 0x20 brown-out control, 0x24 LDO control, 0x28 reset cause, 0x30/0x34/0x38 peripheral reset slots, 0x40+4k run gating k, 0x50+4k sleep gating k, 0x60+4k deep-sleep gating k (k = 0..2), 0x70 and 0x74 general control words, 0x78 MAC low, 0x7C MAC high.

## Requirements
- R1: The interrupt enable register keeps only bits 6:0 of a write. A read of offset 0x18 returns raw status AND enable. Writes to the raw status view at 0x10 are ignored.
- R2: `irq` is high exactly when some bit of (raw AND enable) is set. The line reflects the register state produced by a write from the clock edge of that write.
- R3: A write to 0x18 clears every raw status bit whose written bit is 1 and leaves the others unchanged.
- R4: A write to clock config that takes bit 13 from 1 to 0 sets raw status bit 6. A write that leaves bit 13 at 0 or at 1 does not set it.
- R5: `clk_scale` always equals 5 × (clock config[26:23] + 1).
- R6: A read of 0x04 returns {F, R} with R in bits 4:0 and F in bits 13:5 (others 0), where s = clock config[9:6]. With `chip_variant`=0, F = 25×(s+1) and R = s. With `chip_variant`=1, F = 20×(s+2) and R = 1.
- R7: Brown-out control keeps bits 15:0 of a write, LDO control bits 4:0, and reset cause bits 5:0.
- R8: After reset: brown-out control is 0x7FFD and clock config is 0x078E3AC0. Gating word 0 of each of the three banks is 1 and the other gating words are 0. Raw status, enable, `irq` and `bus_err` are 0.
- R9: 0x78 reads {8'h00, mac[23:0]} and 0x7C reads {8'h00, mac[47:24]}, where MAC byte k sits at `mac_addr`[8k+7:8k]. Writes to both words are ignored.
- R10: Writes to the peripheral reset slots 0x30, 0x34 and 0x38 have no effect, and reads of them return 0.
- R11: A read or write at an offset with no register, or at a non-word-aligned address, returns 0 and changes no state. It raises `bus_err` for exactly the cycle after the access.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd`. The gating words and the two general control words store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an unmapped or misaligned access |
| chip_variant | input | 1 | Selects which PLL setting table is used |
| mac_addr | input | 48 | Factory MAC address, byte k at bits 8k+7:8k |
| clk_scale | output | 8 | Clock scale decoded from clock config |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the PLL-lock edge from several directions: a 1-to-1 write, a true 1-to-0 write, and a 0-to-0 rewrite. A design that tests the level of bit 13 instead of its falling edge would post the interrupt again on the rewrite. Write-one-to-clear is tried with the bit under test both masked and unmasked, and with inverse patterns. A design that clears through the mask, or that stores the written value, would leave the wrong raw bits behind. Unmapped and misaligned accesses are followed by read-back of neighbouring registers, so a decoder that ignores the low address bits or aliases wide offsets would corrupt a real register. Both PLL tables are read at their end entries, which exposes an off-by-one index or swapped variants.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int IRQ_W       = 7;
    localparam int BOR_W       = 16;
    localparam int LDO_W       = 5;
    localparam int RCAUSE_W    = 6;
    localparam int GATE_BANKS  = 3;   // at most 3 so the banks stay below the control words
    localparam int GATE_REGS   = 3;   // at most 4 per bank stride
    localparam int MAC_W       = 48;

    localparam int PLL_PD_BIT  = 13;
    localparam int LOCK_SRC    = 6;
    localparam int XSEL_LO     = 6;
    localparam int XSEL_W      = 4;
    localparam int XSEL_N      = 1 << XSEL_W;
    localparam int DIV_LO      = 23;
    localparam int DIV_W       = 4;
    localparam int SCALE_STEP  = 5;
    localparam int SCALE_W     = 8;
    localparam int PLL_F_W     = 9;
    localparam int PLL_R_W     = 5;

    localparam logic [DATA_W-1:0] CLKCFG_RST = 32'h078E_3AC0;
    localparam logic [BOR_W-1:0]  BOR_RST    = 16'h7FFD;

    // word indices (byte offset / 4)
    localparam int W_CLKCFG  = 0;
    localparam int W_PLLINFO = 1;
    localparam int W_IRQ_RAW = 4;
    localparam int W_IRQ_EN  = 5;
    localparam int W_IRQ_PND = 6;
    localparam int W_BOR     = 8;
    localparam int W_LDO     = 9;
    localparam int W_RCAUSE  = 10;
    localparam int W_PRST0   = 12;
    localparam int PRST_N    = 3;
    localparam int W_GATE0   = 16;
    localparam int GATE_STR  = 4;
    localparam int W_CTL0    = 28;
    localparam int W_CTL1    = 29;
    localparam int W_MAC_LO  = 30;
    localparam int W_MAC_HI  = 31;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_CLKCFG,
        RID_PLLINFO,
        RID_IRQ_RAW,
        RID_IRQ_EN,
        RID_IRQ_PND,
        RID_BOR,
        RID_LDO,
        RID_RCAUSE,
        RID_PRST,
        RID_GATE,
        RID_CTL0,
        RID_CTL1,
        RID_MAC_LO,
        RID_MAC_HI
    } reg_id_e;

    typedef struct packed {
        reg_id_e    id;
        logic [1:0] bank;
        logic [1:0] idx;
        logic       hit;
    } dec_t;

    function automatic logic [DATA_W-1:0] pll_entry(input logic alt,
                                                    input logic [XSEL_W-1:0] sel);
        int f;
        int r;
        if (alt) begin
            f = 20 * (int'(sel) + 2);
            r = 1;
        end else begin
            f = 25 * (int'(sel) + 1);
            r = int'(sel);
        end
        return {{(DATA_W-PLL_F_W-PLL_R_W){1'b0}}, PLL_F_W'(f), PLL_R_W'(r)};
    endfunction

    function automatic logic [SCALE_W-1:0] scale_of(input logic [DIV_W-1:0] d);
        return SCALE_W'(SCALE_STEP * (int'(d) + 1));
    endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr_i[ADDR_W-1:2];

    always_comb begin
        int wi;
        int rel;
        wi  = int'(word);
        rel = wi - W_GATE0;
        dec_o = '{id: RID_NONE, bank: 2'd0, idx: 2'd0, hit: 1'b0};
        if (addr_i[1:0] == 2'b00) begin
            case (wi)
                W_CLKCFG:  dec_o.id = RID_CLKCFG;
                W_PLLINFO: dec_o.id = RID_PLLINFO;
                W_IRQ_RAW: dec_o.id = RID_IRQ_RAW;
                W_IRQ_EN:  dec_o.id = RID_IRQ_EN;
                W_IRQ_PND: dec_o.id = RID_IRQ_PND;
                W_BOR:     dec_o.id = RID_BOR;
                W_LDO:     dec_o.id = RID_LDO;
                W_RCAUSE:  dec_o.id = RID_RCAUSE;
                W_CTL0:    dec_o.id = RID_CTL0;
                W_CTL1:    dec_o.id = RID_CTL1;
                W_MAC_LO:  dec_o.id = RID_MAC_LO;
                W_MAC_HI:  dec_o.id = RID_MAC_HI;
                default:   dec_o.id = RID_NONE;
            endcase
            if (wi >= W_PRST0 && wi < W_PRST0 + PRST_N)
                dec_o.id = RID_PRST;
            if (rel >= 0 && rel < GATE_STR * GATE_BANKS && (rel % GATE_STR) < GATE_REGS) begin
                dec_o.id   = RID_GATE;
                dec_o.bank = 2'(rel / GATE_STR);
                dec_o.idx  = 2'(rel % GATE_STR);
            end
        end
        dec_o.hit = (dec_o.id != RID_NONE);
    end

endmodule

// File: rtl/sysctl_irq.sv
module sysctl_irq
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_we_i,
    input  logic             clr_we_i,
    input  logic [IRQ_W-1:0] wval_i,
    input  logic [IRQ_W-1:0] set_i,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] en_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] raw_q, raw_d;
    logic [IRQ_W-1:0] en_q, en_d;
    logic             irq_q;

    always_comb begin
        raw_d = raw_q;
        if (clr_we_i)
            raw_d = raw_d & ~wval_i;
        raw_d = raw_d | set_i;
        en_d  = en_we_i ? wval_i : en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            raw_q <= raw_d;
            en_q  <= en_d;
            irq_q <= |(raw_d & en_d);
        end
    end

    assign raw_o = raw_q;
    assign en_o  = en_q;
    assign irq_o = irq_q;

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst) irq_o == ((raw_q & en_q) != '0)); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (clr_we_i && set_i == '0) |=> ((raw_q & $past(wval_i)) == '0)); // R3
    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (rst) (!clr_we_i && set_i == '0) |=> $stable(raw_q)); // R1
    AST_LOCK_POSTED: assert property (@(posedge clk) disable iff (rst) set_i[LOCK_SRC] |=> raw_q[LOCK_SRC]); // R4

endmodule

// File: rtl/sysctl_clkcfg.sv
module sysctl_clkcfg
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               variant_i,
    output logic [DATA_W-1:0]  cfg_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic [DATA_W-1:0]  pll_word_o,
    output logic               lock_evt_o
);
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] tbl [2][XSEL_N];

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CLKCFG_RST;
        else if (we_i)
            cfg_q <= wdata_i;
    end

    // falling edge of the power-down bit across one write
    assign lock_evt_o = we_i && cfg_q[PLL_PD_BIT] && !wdata_i[PLL_PD_BIT];

    for (genvar v = 0; v < 2; v++) begin : g_var
        for (genvar s = 0; s < XSEL_N; s++) begin : g_sel
            assign tbl[v][s] = pll_entry(1'(v), XSEL_W'(s));
        end
    end

    assign pll_word_o = tbl[variant_i][cfg_q[XSEL_LO +: XSEL_W]];
    assign scale_o    = scale_of(cfg_q[DIV_LO +: DIV_W]);
    assign cfg_o      = cfg_q;

    AST_LOCK_EDGE: assert property (@(posedge clk) disable iff (rst) lock_evt_o |=> (!cfg_q[PLL_PD_BIT] && $past(cfg_q[PLL_PD_BIT]))); // R4
    AST_SCALE_HOLD: assert property (@(posedge clk) disable iff (rst) !we_i |=> $stable(scale_o)); // R5
    AST_SCALE_MIN: assert property (@(posedge clk) disable iff (rst) scale_o >= SCALE_W'(SCALE_STEP)); // R5

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic               chip_variant,
    input  logic [MAC_W-1:0]   mac_addr,
    output logic [SCALE_W-1:0] clk_scale,
    output logic               irq
);
    localparam int MAC_HALF = MAC_W / 2;

    dec_t dec;

    logic [DATA_W-1:0]   cfg_q;
    logic [DATA_W-1:0]   pll_word;
    logic                lock_evt;
    logic [IRQ_W-1:0]    raw_q, en_q, set_vec;
    logic [BOR_W-1:0]    bor_q;
    logic [LDO_W-1:0]    ldo_q;
    logic [RCAUSE_W-1:0] rcause_q;
    logic [DATA_W-1:0]   ctl0_q, ctl1_q;
    logic [DATA_W-1:0]   gate_q [GATE_BANKS][GATE_REGS];
    logic [DATA_W-1:0]   rd_val;
    logic [DATA_W-1:0]   rdata_q;
    logic                err_q;

    sysctl_addr_dec u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    sysctl_clkcfg u_clk (
        .clk        (clk),
        .rst        (rst),
        .we_i       (bus_wr && dec.id == RID_CLKCFG),
        .wdata_i    (bus_wdata),
        .variant_i  (chip_variant),
        .cfg_o      (cfg_q),
        .scale_o    (clk_scale),
        .pll_word_o (pll_word),
        .lock_evt_o (lock_evt)
    );

    always_comb begin
        set_vec = '0;
        set_vec[LOCK_SRC] = lock_evt;
    end

    sysctl_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .en_we_i  (bus_wr && dec.id == RID_IRQ_EN),
        .clr_we_i (bus_wr && dec.id == RID_IRQ_PND),
        .wval_i   (bus_wdata[IRQ_W-1:0]),
        .set_i    (set_vec),
        .raw_o    (raw_q),
        .en_o     (en_q),
        .irq_o    (irq)
    );

    // narrow control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            bor_q    <= BOR_RST;
            ldo_q    <= '0;
            rcause_q <= '0;
            ctl0_q   <= '0;
            ctl1_q   <= '0;
        end else if (bus_wr) begin
            case (dec.id)
                RID_BOR:    bor_q    <= bus_wdata[BOR_W-1:0];
                RID_LDO:    ldo_q    <= bus_wdata[LDO_W-1:0];
                RID_RCAUSE: rcause_q <= bus_wdata[RCAUSE_W-1:0];
                RID_CTL0:   ctl0_q   <= bus_wdata;
                RID_CTL1:   ctl1_q   <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // clock-gating banks: word 0 of each bank resets to 1
    for (genvar b = 0; b < GATE_BANKS; b++) begin : g_bank
        for (genvar r = 0; r < GATE_REGS; r++) begin : g_word
            localparam logic [DATA_W-1:0] RV = (r == 0) ? DATA_W'(1) : '0;
            always_ff @(posedge clk) begin
                if (rst)
                    gate_q[b][r] <= RV;
                else if (bus_wr && dec.id == RID_GATE && dec.bank == 2'(b) && dec.idx == 2'(r))
                    gate_q[b][r] <= bus_wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (dec.id)
            RID_CLKCFG:  rd_val = cfg_q;
            RID_PLLINFO: rd_val = pll_word;
            RID_IRQ_RAW: rd_val = DATA_W'(raw_q);
            RID_IRQ_EN:  rd_val = DATA_W'(en_q);
            RID_IRQ_PND: rd_val = DATA_W'(raw_q & en_q);
            RID_BOR:     rd_val = DATA_W'(bor_q);
            RID_LDO:     rd_val = DATA_W'(ldo_q);
            RID_RCAUSE:  rd_val = DATA_W'(rcause_q);
            RID_CTL0:    rd_val = ctl0_q;
            RID_CTL1:    rd_val = ctl1_q;
            RID_MAC_LO:  rd_val = DATA_W'(mac_addr[MAC_HALF-1:0]);
            RID_MAC_HI:  rd_val = DATA_W'(mac_addr[MAC_W-1:MAC_HALF]);
            RID_GATE: begin
                for (int b = 0; b < GATE_BANKS; b++)
                    for (int r = 0; r < GATE_REGS; r++)
                        if (dec.bank == 2'(b) && dec.idx == 2'(r))
                            rd_val = gate_q[b][r];
            end
            default:     rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= bus_rd ? rd_val : '0;
            err_q   <= (bus_rd || bus_wr) && !dec.hit;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst) bus_err |-> $past(bus_rd || bus_wr)); // R11
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rd && !dec.hit) |=> (bus_rdata == '0 && bus_err)); // R11
    AST_PRST_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rd && dec.id == RID_PRST) |=> bus_rdata == '0); // R10
    AST_BOR_KEEP: assert property (@(posedge clk) disable iff (rst) !(bus_wr && dec.id == RID_BOR) |=> $stable(bor_q)); // R11

endmodule

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        variant = 1'b0;
    logic [47:0] mac = 48'h6655_4433_2211;
    logic [7:0]  scale;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic last_err;

    always #10 clk = ~clk;

    sysctl_regs dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (wr),
        .bus_rd       (rd),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .bus_err      (err),
        .chip_variant (variant),
        .mac_addr     (mac),
        .clk_scale    (scale),
        .irq          (irq)
    );

    // {addr, write data, read-back expectation}
    localparam int NV = 12;
    localparam logic [71:0] VEC [NV] = '{
        {8'h20, 32'hFFFF_1234, 32'h0000_1234},   // R7 brown-out 16 bits
        {8'h24, 32'hFFFF_FFFF, 32'h0000_001F},   // R7 LDO 5 bits
        {8'h28, 32'hFFFF_FFFF, 32'h0000_003F},   // R7 reset cause 6 bits
        {8'h14, 32'hFFFF_FF80, 32'h0000_0000},   // R1 enable keeps 6:0
        {8'h14, 32'h0000_00AA, 32'h0000_002A},   // R1
        {8'h44, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R12 run gating 1
        {8'h68, 32'h1234_5678, 32'h1234_5678},   // R12 deep-sleep gating 2
        {8'h70, 32'hA5A5_A5A5, 32'hA5A5_A5A5},   // R12 control word 0
        {8'h74, 32'h0F0F_0F0F, 32'h0F0F_0F0F},   // R12 control word 1
        {8'h34, 32'hFFFF_FFFF, 32'h0000_0000},   // R10 reset slot
        {8'h78, 32'hFFFF_FFFF, 32'h0033_2211},   // R9 MAC low read-only
        {8'h10, 32'h0000_007F, 32'h0000_0000}    // R1 raw view read-only
    };
    localparam int VREQ [NV] = '{7, 7, 7, 1, 1, 12, 12, 12, 12, 10, 9, 1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        last_err = err;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
        e = err;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        bus_read(a, d, e);
        check(req, d, exp);
    endtask

    function automatic logic [31:0] pll_exp(input logic alt, input int s);
        int f;
        int r;
        f = alt ? 20 * (s + 2) : 25 * (s + 1);
        r = alt ? 1 : s;
        return 32'((f << 5) | r);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        check("R8 irq", 32'(irq), 0);
        check("R8 err", 32'(err), 0);
        check("R5 reset scale", 32'(scale), 80);
        expect_reg("R8 brown-out", 8'h20, 32'h0000_7FFD);
        expect_reg("R8 clock config", 8'h00, 32'h078E_3AC0);
        expect_reg("R8 run gate 0", 8'h40, 32'h1);
        expect_reg("R8 sleep gate 0", 8'h50, 32'h1);
        expect_reg("R8 deep gate 0", 8'h60, 32'h1);
        expect_reg("R8 run gate 1", 8'h44, 32'h0);
        expect_reg("R8 raw", 8'h10, 32'h0);
        expect_reg("R8 enable", 8'h14, 32'h0);
        expect_reg("R6 reset PLL word", 8'h04, pll_exp(1'b0, 11));

        // table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][71:64], VEC[i][63:32]);
            bus_read(VEC[i][71:64], d, e);
            check($sformatf("R%0d vector %0d", VREQ[i], i), d, VEC[i][31:0]);
        end
        expect_reg("R9 MAC high", 8'h7C, 32'h0066_5544);

        // R4 lock edge detection with the lock source enabled
        bus_write(8'h14, 32'h40);
        bus_write(8'h00, 32'h078E_3AC0);
        expect_reg("R4 1->1 no post", 8'h10, 32'h0);
        check("R2 irq idle", 32'(irq), 0);
        bus_write(8'h00, 32'h078E_1AC0);
        check("R2 irq after lock", 32'(irq), 1);
        expect_reg("R4 1->0 posts", 8'h10, 32'h40);
        expect_reg("R1 pending", 8'h18, 32'h40);
        bus_write(8'h18, 32'h40);
        check("R2 irq cleared", 32'(irq), 0);
        expect_reg("R3 W1C clears", 8'h10, 32'h0);
        bus_write(8'h00, 32'h078E_1AC0);
        expect_reg("R4 0->0 no post", 8'h10, 32'h0);

        // R3 with the source masked
        bus_write(8'h14, 32'h0);
        bus_write(8'h00, 32'h078E_3AC0);
        bus_write(8'h00, 32'h078E_1AC0);
        check("R2 masked no irq", 32'(irq), 0);
        expect_reg("R1 masked pending", 8'h18, 32'h0);
        bus_write(8'h18, 32'hFFFF_FFBF);
        expect_reg("R3 other bits leave raw", 8'h10, 32'h40);
        bus_write(8'h18, 32'h0000_0040);
        expect_reg("R3 masked W1C clears", 8'h10, 32'h0);

        // R5 scale decode
        bus_write(8'h00, 32'h0);
        check("R5 scale min", 32'(scale), 5);
        bus_write(8'h00, 32'h0380_0000);
        check("R5 scale field 7", 32'(scale), 40);

        // R6 PLL tables at both ends
        bus_write(8'h00, 32'h0000_0000);
        expect_reg("R6 variant0 sel0", 8'h04, pll_exp(1'b0, 0));
        bus_write(8'h00, 32'h0000_03C0);
        expect_reg("R6 variant0 sel15", 8'h04, pll_exp(1'b0, 15));
        @(negedge clk);
        variant = 1'b1;
        expect_reg("R6 variant1 sel15", 8'h04, pll_exp(1'b1, 15));
        bus_write(8'h00, 32'h0000_0000);
        expect_reg("R6 variant1 sel0", 8'h04, pll_exp(1'b1, 0));

        // R11 unmapped and misaligned accesses
        bus_read(8'h08, d, e);
        check("R11 unmapped read data", d, 32'h0);
        check("R11 unmapped read err", 32'(e), 1);
        @(negedge clk);
        check("R11 err one cycle", 32'(err), 0);
        bus_write(8'h80, 32'hFFFF_FFFF);
        check("R11 unmapped write err", 32'(last_err), 1);
        bus_write(8'h21, 32'h0000_0000);
        check("R11 misaligned write err", 32'(last_err), 1);
        expect_reg("R11 brown-out untouched", 8'h20, 32'h0000_1234);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        expect_reg("R11 enable untouched", 8'h14, 32'h0);
        bus_read(8'h7D, d, e);
        check("R11 misaligned read err", 32'(e), 1);
        check("R11 misaligned read data", d, 32'h0);

        // R10 reset slots do not disturb neighbours
        bus_write(8'h30, 32'hFFFF_FFFF);
        check("R10 write no err", 32'(last_err), 0);
        expect_reg("R10 slot read", 8'h38, 32'h0);
        expect_reg("R10 reset cause kept", 8'h28, 32'h3F);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule